// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block is the transmit half of a bit error rate tester. It drives one serial data bit per enabled clock, taken either from a shift register with a programmable length and feedback tap mask, or from a user word of 1 to 32 bits sent in a loop. A bit-enable input gaps the clock. While the enable is low, the generator's position and the output bit are frozen. This lets a test occupy only chosen time slots of a framed line.

Deliberate errors can be added on top of the stream. A one-shot request inverts the next transmitted bit. A decade-rate setting inverts every 10th, 100th and so on, up to every 10,000,000th transmitted bit. Software sets everything through a small write port that has one address per setting.

Top module: `bert_patgen`

## Requirements
- R1: In pseudorandom mode (control word bit 0 = 0) with length L = control bits [12:8] + 1, each enabled bit is stage L-1 of the register. The register then shifts toward higher stages, and the new stage 0 is the XOR of the register ANDed with the tap word (address 1) and with the L-bit mask. Stages at L and above stay zero.
- R2: If the active stages of the register are all zero, or a sequence restart is pending, the register is loaded with the seed word (address 2) masked to L bits before that bit is produced. A value of 1 is used instead if the masked seed is zero.
- R3: In repetitive mode (control bit 0 = 1) the word at address 2 is sent from bit L-1 down to bit 0, then again from bit L-1, with no idle bits between repetitions.
- R4: A clock with bit_en low, or with cfg_we high, leaves data_out and the sequence position unchanged.
- R5: A write to address 4 inverts exactly one bit, the next one transmitted.
- R6: Rate code n in bits [2:0] of address 3, with n from 1 to 7, inverts every 10^n-th transmitted bit, counted from the write of the code. Code 0 disables this.
- R7: A write to address 0, 1 or 2 restarts the sequence at its first bit and drops any pending one-shot error and the rate count.
- R8: After reset, data_out is 0, the mode is pseudorandom with L = 32, the tap and seed words are zero, and error insertion is off.
- R9: A write cycle transmits no bit, even with bit_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; may stop for any time |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | 0 control, 1 taps, 2 seed/pattern, 3 rate, 4 one-shot error |
| cfg_wdata | input | 32 | Write data |
| bit_en | input | 1 | Gapped-clock enable: transmit a bit this clock |
| data_out | output | 1 | Serial test pattern |

## Verification
A bit is due on data_out at the rising edge where bit_en is high and cfg_we is low, with one register between the stimulus and the pin. A write changes the settings at its own edge, so the next enabled edge already uses them. The bench drives each cycle at a falling edge, steps its reference model at the rising edge, and compares at the next falling edge. Bit-count results for the error rates are collected over exactly the number of enabled bits that the decade implies.

// File: rtl/bert_pkg.sv
`timescale 1ns/1ps
package bert_pkg;
    localparam int DW = 32;            // pattern / register width
    localparam int LW = $clog2(DW);    // length field width
    localparam int AW = 3;             // setting address width
    localparam int RW = 3;             // rate code width
    localparam int DECADES = 7;        // highest rate code
    localparam int CW = 24;            // rate counter width, holds 10^DECADES

    localparam logic [AW-1:0] A_CTRL   = 3'd0;
    localparam logic [AW-1:0] A_TAPS   = 3'd1;
    localparam logic [AW-1:0] A_SEED   = 3'd2;
    localparam logic [AW-1:0] A_RATE   = 3'd3;
    localparam logic [AW-1:0] A_SINGLE = 3'd4;
    localparam int LEN_LSB = 8;

    typedef struct packed {
        logic          rep_mode;
        logic [LW-1:0] len_m1;
        logic [DW-1:0] taps;
        logic [DW-1:0] seed;
        logic [RW-1:0] rate;
    } cfg_t;

    function automatic logic [CW-1:0] decade_limit(input logic [RW-1:0] code);
        logic [31:0] v;
        v = 32'd1;
        for (int i = 1; i <= DECADES; i++) begin
            if (i <= int'(code)) v = v * 32'd10;
        end
        return v[CW-1:0];
    endfunction
endpackage

// File: rtl/bert_cfg_regs.sv
`timescale 1ns/1ps
module bert_cfg_regs
    import bert_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic          restart,
    output logic          rate_wr,
    output logic          single_req
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                A_CTRL: begin
                    cfg_d.rep_mode = wdata[0];
                    cfg_d.len_m1   = wdata[LEN_LSB +: LW];
                end
                A_TAPS:  cfg_d.taps = wdata;
                A_SEED:  cfg_d.seed = wdata;
                A_RATE:  cfg_d.rate = wdata[RW-1:0];
                default: ;
            endcase
        end
        restart    = we && (addr == A_CTRL || addr == A_TAPS || addr == A_SEED);
        rate_wr    = we && (addr == A_RATE);
        single_req = we && (addr == A_SINGLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q          <= '0;
            cfg_q.len_m1   <= LW'(DW - 1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bert_err_inject.sv
`timescale 1ns/1ps
module bert_err_inject
    import bert_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rate,
    input  logic          restart,
    input  logic          rate_wr,
    input  logic          single_req,
    input  logic          step,
    output logic          flip,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] limit_o,
    output logic          rate_on_o
);
    typedef struct packed {
        logic          pend;
        logic [CW-1:0] cnt;
    } inj_t;

    inj_t r_d, r_q;
    logic [CW-1:0] limit;
    logic          rate_on, hit;

    always_comb begin
        limit   = decade_limit(rate);
        rate_on = (rate != '0);
        hit     = rate_on && (r_q.cnt == limit - 1'b1);
        flip    = step && (r_q.pend || hit);
        r_d     = r_q;
        if (restart) begin
            r_d.pend = 1'b0;
            r_d.cnt  = '0;
        end else begin
            if (single_req) r_d.pend = 1'b1;
            if (rate_wr)    r_d.cnt  = '0;
            if (step) begin
                r_d.pend = 1'b0;
                if (rate_on) r_d.cnt = hit ? '0 : r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cnt_o     = r_q.cnt;
    assign limit_o   = limit;
    assign rate_on_o = rate_on;
endmodule

// File: rtl/bert_seq_core.sv
`timescale 1ns/1ps
module bert_seq_core
    import bert_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_t          cfg,
    input  logic          restart,
    input  logic          step,
    input  logic          flip,
    output logic          data_out,
    output logic [DW-1:0] state_o,
    output logic [LW-1:0] pos_o,
    output logic          fresh_o,
    output logic [DW-1:0] mask_o
);
    localparam logic [LW-1:0] TOP_STAGE = LW'(DW - 1);

    typedef struct packed {
        logic [DW-1:0] st;
        logic [LW-1:0] pos;
        logic          fresh;
        logic          out;
    } core_t;

    core_t r_d, r_q;
    logic [DW-1:0] mask, seed_m, fallback, eff_st;
    logic [LW-1:0] eff_pos;
    logic          cur_bit, fb;

    always_comb begin
        mask     = {DW{1'b1}} >> (TOP_STAGE - cfg.len_m1);
        seed_m   = cfg.seed & mask;
        fallback = (seed_m != '0) ? seed_m : {{(DW-1){1'b0}}, 1'b1};
        eff_st   = (r_q.fresh || ((r_q.st & mask) == '0)) ? fallback : r_q.st;
        eff_pos  = r_q.fresh ? cfg.len_m1 : r_q.pos;
        fb       = ^(eff_st & cfg.taps & mask);
        cur_bit  = cfg.rep_mode ? cfg.seed[eff_pos] : eff_st[cfg.len_m1];

        r_d = r_q;
        if (restart) begin
            r_d.fresh = 1'b1;
        end else if (step) begin
            r_d.out   = cur_bit ^ flip;
            r_d.fresh = 1'b0;
            if (cfg.rep_mode)
                r_d.pos = (eff_pos == '0) ? cfg.len_m1 : eff_pos - 1'b1;
            else
                r_d.st = {eff_st[DW-2:0], fb} & mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.fresh <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_out = r_q.out;
    assign state_o  = r_q.st;
    assign pos_o    = r_q.pos;
    assign fresh_o  = r_q.fresh;
    assign mask_o   = mask;
endmodule

// File: rtl/bert_patgen.sv
`timescale 1ns/1ps
module bert_patgen
    import bert_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          bit_en,
    output logic          data_out
);
    cfg_t          cfg;
    logic          restart, rate_wr, single_req, step, flip;
    logic [DW-1:0] core_state, core_mask;
    logic [LW-1:0] core_pos;
    logic          core_fresh;
    logic [CW-1:0] err_cnt, err_limit;
    logic          err_on;

    assign step = bit_en && !cfg_we;

    bert_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .cfg(cfg), .restart(restart), .rate_wr(rate_wr), .single_req(single_req)
    );

    bert_err_inject u_inj (
        .clk(clk), .rst_n(rst_n), .rate(cfg.rate), .restart(restart),
        .rate_wr(rate_wr), .single_req(single_req), .step(step), .flip(flip),
        .cnt_o(err_cnt), .limit_o(err_limit), .rate_on_o(err_on)
    );

    bert_seq_core u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .restart(restart), .step(step),
        .flip(flip), .data_out(data_out), .state_o(core_state), .pos_o(core_pos),
        .fresh_o(core_fresh), .mask_o(core_mask)
    );
endmodule

// File: rtl/bert_patgen_chk.sv
`timescale 1ns/1ps
module bert_patgen_chk
    import bert_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          step,
    input logic          data_out,
    input logic          rep_mode,
    input logic          fresh,
    input logic [LW-1:0] pos,
    input logic [LW-1:0] len_m1,
    input logic [DW-1:0] state,
    input logic [DW-1:0] mask,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] limit,
    input logic          rate_on
);
    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(data_out));

    // R6
    rate_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_on |-> (cnt < limit));

    // R3
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_mode && !fresh) |-> (pos <= len_m1));

    // R1
    stages_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rep_mode && !fresh) |-> ((state & ~mask) == '0));
endmodule

bind bert_patgen bert_patgen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .data_out(data_out),
    .rep_mode(cfg.rep_mode), .fresh(core_fresh), .pos(core_pos),
    .len_m1(cfg.len_m1), .state(core_state), .mask(core_mask),
    .cnt(err_cnt), .limit(err_limit), .rate_on(err_on)
);

// File: tb/sim_bert_patgen.sv
`timescale 1ns/1ps
module sim_bert_patgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bit_en = 1'b0;
    logic        data_out;

    int nchk = 0, nerr = 0;
    bit done = 0;

    // reference model of the requirements
    bit          m_rep = 0;
    logic [4:0]  m_lm1 = 5'd31;
    logic [31:0] m_taps = 0, m_seed = 0, m_st = 0;
    logic [2:0]  m_rate = 0;
    logic [4:0]  m_pos = 0;
    bit          m_fresh = 1, m_pend = 0, m_out = 0;
    int          m_cnt = 0;
    bit          bits[$];

    always #5 clk = ~clk;

    bert_patgen u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
                    .cfg_wdata(cfg_wdata), .bit_en(bit_en), .data_out(data_out));

    function automatic logic [31:0] f_mask(input logic [4:0] lm1);
        return 32'hFFFF_FFFF >> (5'd31 - lm1);
    endfunction

    function automatic int f_limit(input logic [2:0] code);
        int v = 1;
        for (int i = 0; i < int'(code); i++) v = v * 10;
        return v;
    endfunction

    task automatic ck(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input bit en, input bit we, input logic [2:0] a, input logic [31:0] d);
        logic [31:0] msk, sm, fbk, eff;
        logic [4:0]  ep;
        bit          b, hit, fl;
        if (we) begin
            case (a)
                3'd0: begin m_rep = d[0]; m_lm1 = d[12:8]; end
                3'd1: m_taps = d;
                3'd2: m_seed = d;
                3'd3: m_rate = d[2:0];
                default: ;
            endcase
            if (a <= 3'd2) begin m_fresh = 1; m_pend = 0; m_cnt = 0; end
            if (a == 3'd3) m_cnt = 0;
            if (a == 3'd4) m_pend = 1;
        end else if (en) begin
            msk = f_mask(m_lm1);
            sm  = m_seed & msk;
            fbk = (sm != 0) ? sm : 32'd1;
            eff = (m_fresh || (m_st & msk) == 0) ? fbk : m_st;
            ep  = m_fresh ? m_lm1 : m_pos;
            hit = (m_rate != 0) && (m_cnt == f_limit(m_rate) - 1);
            fl  = m_pend || hit;
            m_pend = 0;
            if (m_rate != 0) m_cnt = hit ? 0 : m_cnt + 1;
            b = m_rep ? m_seed[ep] : eff[m_lm1];
            m_out = b ^ fl;
            if (m_rep) m_pos = (ep == 0) ? m_lm1 : ep - 5'd1;
            else       m_st  = {eff[30:0], ^(eff & m_taps & msk)} & msk;
            m_fresh = 0;
        end
    endtask

    // one clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit en, input bit we, input logic [2:0] a, input logic [31:0] d,
                       input string tag);
        bit_en = en; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        model_edge(en, we, a, d);
        @(negedge clk);
        ck(data_out === m_out, tag, int'(data_out), int'(m_out));
        if (en && !we) bits.push_back(data_out);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        cyc(1'b1, 1'b1, a, d, tag);   // enable high: the write still sends no bit (R9)
    endtask

    task automatic run(input int n, input string tag);
        bits.delete();
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 32'd0, tag);
    endtask

    function automatic int ones();
        int c = 0;
        foreach (bits[i]) c += int'(bits[i]);
        return c;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int s;
        s = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ck(data_out === 1'b0, "R8 reset output", int'(data_out), 0);
        // R8: default length 32, zero seed falls back to 1: bit 31 shows after 31 zeros
        run(32, "R8 default sequence");
        ck(ones() == 1 && bits[31] == 1, "R8 default length", ones(), 1);

        // R1: L=4, taps on stages 3 and 2 -> maximal, period 15
        wr(3'd0, 32'h0000_0300, "R7 ctrl write");
        wr(3'd1, 32'h0000_000C, "R1 taps write");
        wr(3'd2, 32'h0000_0001, "R1 seed write");
        run(30, "R1 prbs4");
        begin
            bit per = 1;
            int c = 0;
            for (int i = 0; i < 15; i++) begin
                if (bits[i] != bits[i+15]) per = 0;
                c += int'(bits[i]);
            end
            ck(per, "R1 period 15", int'(per), 1);
            ck(c == 8, "R1 ones per period", c, 8);
        end

        // R2: zero seed behaves as seed 1: 0,0,0,1 first
        wr(3'd2, 32'h0, "R2 zero seed");
        run(4, "R2 lockup");
        ck({bits[0], bits[1], bits[2], bits[3]} == 4'b0001, "R2 first bits",
           int'({bits[0], bits[1], bits[2], bits[3]}), 1);

        // R3: L=5, pattern 10110, MSB first, seamless wrap
        wr(3'd0, 32'h0000_0401, "R3 ctrl");
        wr(3'd2, 32'h0000_0016, "R3 pattern");
        run(7, "R3 repeat");
        ck({bits[0], bits[1], bits[2], bits[3], bits[4], bits[5], bits[6]} == 7'b1011010,
           "R3 order", int'({bits[0], bits[1], bits[2], bits[3], bits[4], bits[5], bits[6]}), 7'b1011010);

        // R4: gapped enable holds output and position
        for (int i = 0; i < 40; i++) cyc(($urandom % 3) == 0, 1'b0, 3'd0, 32'd0, "R4 gap hold");

        // R5: L=1 all-zero pattern, one-shot error
        wr(3'd0, 32'h0000_0001, "R5 ctrl");
        wr(3'd2, 32'h0, "R5 pattern");
        wr(3'd4, 32'h0, "R5 request");
        cyc(1'b0, 1'b0, 3'd0, 32'd0, "R5 gapped before");
        run(6, "R5 single");
        ck(ones() == 1 && bits[0] == 1, "R5 one flip", ones(), 1);

        // R7: restart drops pending error
        wr(3'd4, 32'h0, "R7 request");
        wr(3'd2, 32'h0, "R7 rewrite");
        run(5, "R7 cleared");
        ck(ones() == 0, "R7 no flip", ones(), 0);

        // R6: decade rates
        wr(3'd3, 32'h1, "R6 rate 1");
        run(100, "R6 rate 1");
        ck(ones() == 10 && bits[9] == 1 && bits[8] == 0, "R6 every 10", ones(), 10);
        wr(3'd3, 32'h2, "R6 rate 2");
        run(300, "R6 rate 2");
        ck(ones() == 3 && bits[99] == 1, "R6 every 100", ones(), 3);
        wr(3'd3, 32'h0, "R6 off");
        run(50, "R6 off");
        ck(ones() == 0, "R6 off count", ones(), 0);

        // R9: writes with enable high transmit nothing
        wr(3'd5, 32'hFFFF_FFFF, "R9 unused address");
        wr(3'd6, 32'h1234_5678, "R9 write hold");

        // random mix
        for (int r = 0; r < 60; r++) begin
            wr(3'd0, {19'd0, 5'($urandom), 7'd0, 1'($urandom)}, "rand ctrl R1 R3");
            wr(3'd1, $urandom, "rand taps");
            wr(3'd2, $urandom, "rand seed");
            wr(3'd3, 32'($urandom % 3), "rand rate R6");
            for (int i = 0; i < 80; i++) begin
                int k = $urandom % 100;
                if (k < 4)       wr(3'd4, 32'h0, "rand single R5");
                else if (k < 6)  wr(3'd2, $urandom, "rand restart R7");
                else             cyc(k < 75, 1'b0, 3'd0, 32'd0, "rand stream R4");
            end
        end
        finish_run();
    end
endmodule